// File: doc/BRIEF.md
# Signed Integer Divider Peripheral

A register-mapped arithmetic unit that divides a signed 32-bit dividend by a signed 16-bit divisor. Software stores the dividend, then writes the divisor. That divisor write is the only trigger: it captures both operands and launches a multi-cycle shift-and-subtract computation. When the computation ends, the block places a 32-bit quotient and a sign-extended 16-bit remainder in result registers that software can read.

A read-only status word carries two flags. The completion flag drops while the engine is working. The zero-divisor flag is refreshed by every divisor write. A division by zero does not run the iterative engine: it completes on the next cycle with a fixed result pattern. If the divisor is written again while a computation is still running, the running computation is abandoned and a new one starts from the newly written operands.

Top module: `sdiv_periph`

## Requirements
- R1: After reset the dividend, divisor, quotient and remainder registers read 0 and the status word reads 0x00000001 (completion bit 0 set, zero-divisor bit 1 clear).
- R2: Word offsets: 0x00 dividend (32 bits, read/write), 0x04 divisor (bits [15:0], reads back zero-extended), 0x08 quotient, 0x0C remainder, 0x10 status; any other offset reads 0.
- R3: A write to offset 0x04 starts a computation. The operands are the written divisor and the dividend register value at the moment of that write.
- R4: For a nonzero divisor, status bit 0 reads 0 during the 33 cycles after the divisor write cycle and reads 1 from the 34th cycle onward.
- R5: Each divisor write sets status bit 1 to 1 if the written divisor is 0 and to 0 otherwise, starting the cycle after the write.
- R6: The quotient is the two's complement quotient truncated toward zero. The remainder has the sign of the dividend. 0x80000000 divided by -1 gives the quotient 0x80000000 and the remainder 0.
- R7: Remainder bits [31:16] always equal copies of remainder bit 15.
- R8: With a zero divisor, status bit 0 reads 0 for one cycle after the write and then reads 1. The quotient reads 0xFFFFFFFF and the remainder reads the dividend's bits [15:0] sign-extended.
- R9: A divisor write while a computation is running abandons it and restarts from the new operands. The timing of R4 then counts from the new write, and only the new result appears.
- R10: Writes to offsets 0x08, 0x0C and 0x10 change nothing. The quotient and remainder keep their values until the next computation completes.
- R11: Rewriting the dividend while a computation is running does not change that computation's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | 5 | Byte offset of the accessed register (word aligned) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The assertions assume that the bus presents at most one access per cycle, with a defined `wr_en` and a word-aligned `addr` held steady around the clock edge. The latency and result-hold properties also assume that the results change only through the engine, so no other agent touches the internal state. The bench keeps within these assumptions by driving every access from tasks that change inputs only on the falling edge. It issues single-cycle write strobes and uses only the five mapped offsets plus one unmapped aligned offset. The random operands cover the full 32-bit and 16-bit ranges, with about one divisor in eight forced to zero and a share drawn from the extreme values.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    localparam int unsigned DVD_W  = 32;
    localparam int unsigned DVS_W  = 16;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DVD = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFS_DVS = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFS_QUO = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFS_REM = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFS_STS = ADDR_W'(8'h10);

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_FIX  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic quo_neg;
        logic rem_neg;
    } sign_fix_t;

    typedef struct packed {
        logic zero_div;
        logic finish;
    } status_t;

endpackage

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int unsigned DVS_W = sdiv_pkg::DVS_W
) (
    input  logic [DVS_W-1:0] r_in,
    input  logic             bit_in,
    input  logic [DVS_W-1:0] d,
    output logic [DVS_W-1:0] r_out,
    output logic             q_bit
);
    localparam int unsigned EXT_W = DVS_W + 1;

    logic [EXT_W-1:0] shifted;
    logic [EXT_W-1:0] diff;

    always_comb begin
        shifted = {r_in, bit_in};
        diff    = shifted - {1'b0, d};
        q_bit   = (shifted >= {1'b0, d});
        r_out   = q_bit ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
    end
endmodule

// File: rtl/sdiv_engine.sv
module sdiv_engine
    import sdiv_pkg::*;
#(
    parameter int unsigned DVD_W = sdiv_pkg::DVD_W,
    parameter int unsigned DVS_W = sdiv_pkg::DVS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dvd,
    input  logic [DVS_W-1:0] dvs,
    output logic             busy,
    output logic             res_valid,
    output logic [DVD_W-1:0] res_quo,
    output logic [DVS_W-1:0] res_rem
);
    localparam int unsigned CNT_W = $clog2(DVD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    eng_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVD_W-1:0] q_acc;
    logic [DVS_W-1:0] r_acc;
    logic [DVS_W-1:0] d_mag;
    sign_fix_t        sgn_q;

    logic [DVS_W-1:0] r_nxt;
    logic             q_bit;

    sdiv_step #(.DVS_W(DVS_W)) u_step (
        .r_in  (r_acc),
        .bit_in(q_acc[DVD_W-1]),
        .d     (d_mag),
        .r_out (r_nxt),
        .q_bit (q_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            q_acc   <= '0;
            r_acc   <= '0;
            d_mag   <= '0;
            sgn_q   <= '0;
        end else if (start) begin
            cnt_q <= '0;
            if (dvs == '0) begin
                // zero divisor: fixed pattern, skip the iterations
                q_acc   <= '1;
                r_acc   <= dvd[DVS_W-1:0];
                d_mag   <= '0;
                sgn_q   <= '0;
                state_q <= ENG_FIX;
            end else begin
                q_acc         <= dvd[DVD_W-1] ? (~dvd + 1'b1) : dvd;
                r_acc         <= '0;
                d_mag         <= dvs[DVS_W-1] ? (~dvs + 1'b1) : dvs;
                sgn_q.quo_neg <= dvd[DVD_W-1] ^ dvs[DVS_W-1];
                sgn_q.rem_neg <= dvd[DVD_W-1];
                state_q       <= ENG_RUN;
            end
        end else begin
            case (state_q)
                ENG_RUN: begin
                    q_acc <= {q_acc[DVD_W-2:0], q_bit};
                    r_acc <= r_nxt;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ENG_FIX;
                end
                ENG_FIX: state_q <= ENG_IDLE;
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ENG_IDLE);
        res_valid = (state_q == ENG_FIX) && !start;
        res_quo   = sgn_q.quo_neg ? (~q_acc + 1'b1) : q_acc;
        res_rem   = sgn_q.rem_neg ? (~r_acc + 1'b1) : r_acc;
    end
endmodule

// File: rtl/sdiv_regs.sv
module sdiv_regs
    import sdiv_pkg::*;
#(
    parameter int unsigned DVD_W  = sdiv_pkg::DVD_W,
    parameter int unsigned DVS_W  = sdiv_pkg::DVS_W,
    parameter int unsigned ADDR_W = sdiv_pkg::ADDR_W,
    parameter int unsigned DATA_W = sdiv_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_busy,
    input  logic              res_valid,
    input  logic [DVD_W-1:0]  res_quo,
    input  logic [DVS_W-1:0]  res_rem,
    output logic              start,
    output logic [DVD_W-1:0]  dvd_q,
    output logic [DVS_W-1:0]  dvs_new,
    output logic [DATA_W-1:0] quo_q,
    output logic [DATA_W-1:0] rem_q,
    output logic              dz_q,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned SEXT_W = DATA_W - DVS_W;

    logic [DVS_W-1:0] dvs_q;
    status_t          sts;

    always_comb begin
        start   = wr_en && (addr == OFS_DVS);
        dvs_new = wdata[DVS_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dz_q  <= 1'b0;
        end else begin
            if (wr_en && addr == OFS_DVD) dvd_q <= wdata[DVD_W-1:0];
            if (start) begin
                dvs_q <= dvs_new;
                dz_q  <= (dvs_new == '0);
            end
            if (res_valid) begin
                quo_q <= DATA_W'(res_quo);
                rem_q <= {{SEXT_W{res_rem[DVS_W-1]}}, res_rem};
            end
        end
    end

    always_comb begin
        sts.finish   = !eng_busy;
        sts.zero_div = dz_q;
        case (addr)
            OFS_DVD: rdata = DATA_W'(dvd_q);
            OFS_DVS: rdata = DATA_W'(dvs_q);
            OFS_QUO: rdata = quo_q;
            OFS_REM: rdata = rem_q;
            OFS_STS: rdata = DATA_W'(sts);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdiv_periph.sv
module sdiv_periph
    import sdiv_pkg::*;
#(
    parameter int unsigned DVD_W  = sdiv_pkg::DVD_W,
    parameter int unsigned DVS_W  = sdiv_pkg::DVS_W,
    parameter int unsigned ADDR_W = sdiv_pkg::ADDR_W,
    parameter int unsigned DATA_W = sdiv_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              start;
    logic [DVD_W-1:0]  dvd_q;
    logic [DVS_W-1:0]  dvs_new;
    logic [DATA_W-1:0] quo_q;
    logic [DATA_W-1:0] rem_q;
    logic              dz_flag;
    logic              eng_busy;
    logic              finish_flag;
    logic              res_valid;
    logic [DVD_W-1:0]  res_quo;
    logic [DVS_W-1:0]  res_rem;

    assign finish_flag = !eng_busy;

    sdiv_regs #(
        .DVD_W(DVD_W), .DVS_W(DVS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .eng_busy (eng_busy),
        .res_valid(res_valid),
        .res_quo  (res_quo),
        .res_rem  (res_rem),
        .start    (start),
        .dvd_q    (dvd_q),
        .dvs_new  (dvs_new),
        .quo_q    (quo_q),
        .rem_q    (rem_q),
        .dz_q     (dz_flag),
        .rdata    (rdata)
    );

    sdiv_engine #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dvd      (dvd_q),
        .dvs      (dvs_new),
        .busy     (eng_busy),
        .res_valid(res_valid),
        .res_quo  (res_quo),
        .res_rem  (res_rem)
    );
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker
    import sdiv_pkg::*;
#(
    parameter int unsigned DVD_W  = sdiv_pkg::DVD_W,
    parameter int unsigned DVS_W  = sdiv_pkg::DVS_W,
    parameter int unsigned ADDR_W = sdiv_pkg::ADDR_W,
    parameter int unsigned DATA_W = sdiv_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DVS_W-1:0]  dvs_wdata,
    input logic              finish_flag,
    input logic              dz_flag,
    input logic [DATA_W-1:0] quo_q,
    input logic [DATA_W-1:0] rem_q
);
    localparam logic [7:0] LAT = 8'(DVD_W + 1);

    logic       wr_dvs;
    logic [7:0] lat_cnt;

    assign wr_dvs = wr_en && (addr == OFS_DVS);

    always_ff @(posedge clk) begin
        if (rst)                                  lat_cnt <= '0;
        else if (wr_dvs)                          lat_cnt <= '0;
        else if (!finish_flag && lat_cnt != 8'hFF) lat_cnt <= lat_cnt + 1'b1;
    end

    a_r4_low_after_start: assert property (@(posedge clk) disable iff (rst)
        wr_dvs |=> !finish_flag);

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        ($rose(finish_flag) && !dz_flag) |-> (lat_cnt == LAT));

    a_r5_dz_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr_dvs |=> (dz_flag == ($past(dvs_wdata) == '0)));

    a_r7_rem_sign_ext: assert property (@(posedge clk) disable iff (rst)
        rem_q[DATA_W-1:DVS_W] == {(DATA_W-DVS_W){rem_q[DVS_W-1]}});

    a_r8_zero_finishes_next: assert property (@(posedge clk) disable iff (rst)
        (wr_dvs && dvs_wdata == '0) ##1 !wr_dvs |=> finish_flag);

    a_r8_zero_all_ones: assert property (@(posedge clk) disable iff (rst)
        ($rose(finish_flag) && dz_flag) |-> (quo_q == '1));

    a_r10_results_hold: assert property (@(posedge clk) disable iff (rst)
        (finish_flag && !wr_dvs) |=> ($stable(quo_q) && $stable(rem_q)));
endmodule

bind sdiv_periph sdiv_checker #(
    .DVD_W(DVD_W), .DVS_W(DVS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .dvs_wdata  (wdata[DVS_W-1:0]),
    .finish_flag(finish_flag),
    .dz_flag    (dz_flag),
    .quo_q      (quo_q),
    .rem_q      (rem_q)
);

// File: tb/sim_sdiv_periph.sv
`timescale 1ns/1ps
module sim_sdiv_periph;
    localparam logic [4:0] A_DVD = 5'h00, A_DVS = 5'h04, A_QUO = 5'h08,
                           A_REM = 5'h0C, A_STS = 5'h10, A_BAD = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdiv_periph u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic void ref_div(input logic [31:0] a, input logic [15:0] b,
                                    output logic [31:0] q, output logic [31:0] r);
        longint sa, sb, lq, lr;
        if (b == 16'h0) begin
            q = 32'hFFFF_FFFF;
            r = {{16{a[15]}}, a[15:0]};
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            lq = sa / sb;
            lr = sa % sb;
            q = lq[31:0];
            r = lr[31:0];
        end
    endfunction

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 60; i++) begin
            rd(A_STS, s);
            if (s[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] a, input logic [15:0] b);
        logic [31:0] eq, er, v;
        ref_div(a, b, eq, er);
        wr(A_DVD, a);
        wr(A_DVS, {16'h0, b});
        wait_done();
        rd(A_QUO, v); chk({tag, " R6 quotient"}, v, eq);
        rd(A_REM, v); chk({tag, " R7 remainder"}, v, er);
        rd(A_STS, v); chk({tag, " R5 status"}, v, {30'h0, (b == 16'h0), 1'b1});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a;
        logic [15:0] b;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_DVD, v); chk("R1 dividend", v, 32'h0);
        rd(A_DVS, v); chk("R1 divisor", v, 32'h0);
        rd(A_QUO, v); chk("R1 quotient", v, 32'h0);
        rd(A_REM, v); chk("R1 remainder", v, 32'h0);
        rd(A_STS, v); chk("R1 status", v, 32'h1);

        // R4 exact completion timing, R3 start
        wr(A_DVD, 32'd100);
        wr(A_DVS, 32'd7);
        rd(A_STS, v); chk("R4 finish low after write", v, 32'h0);
        repeat (32) @(negedge clk);
        rd(A_STS, v); chk("R4 finish still low at cycle 33", v, 32'h0);
        @(negedge clk);
        rd(A_STS, v); chk("R4 finish high at cycle 34", v, 32'h1);
        rd(A_QUO, v); chk("R3 quotient 100/7", v, 32'd14);
        rd(A_REM, v); chk("R3 remainder 100/7", v, 32'd2);

        // R2 divisor readback zero-extended, unmapped offset
        wr(A_DVS, 32'hABCD_FFF9);
        rd(A_DVS, v); chk("R2 divisor readback", v, 32'h0000_FFF9);
        rd(A_BAD, v); chk("R2 unmapped offset", v, 32'h0);
        wait_done();

        // R8 divide by zero
        wr(A_DVD, 32'hFFFF_8001);
        wr(A_DVS, 32'h0);
        rd(A_STS, v); chk("R8 zero busy one cycle", v, 32'h2);
        @(negedge clk);
        rd(A_STS, v); chk("R8 zero finish next", v, 32'h3);
        rd(A_QUO, v); chk("R8 zero quotient", v, 32'hFFFF_FFFF);
        rd(A_REM, v); chk("R8 zero remainder", v, 32'hFFFF_8001);

        // R6 overflow corner and sign combinations
        run_op("R6 min/-1", 32'h8000_0000, 16'hFFFF);
        run_op("R6 neg/pos", 32'hFFFF_FFCE, 16'd6);
        run_op("R6 pos/neg", 32'd50, 16'hFFFA);
        run_op("R6 neg/neg", 32'hFFFF_FFCE, 16'hFFFA);
        run_op("R6 min/min16", 32'h8000_0000, 16'h8000);
        run_op("R7 rem neg max", 32'h8000_0001, 16'h8000);

        // R9 restart during busy
        wr(A_DVD, 32'd1000);
        wr(A_DVS, 32'd3);
        repeat (10) @(negedge clk);
        wr(A_DVS, 32'h0000_FFF9);
        rd(A_STS, v); chk("R9 busy after restart", v, 32'h0);
        repeat (32) @(negedge clk);
        rd(A_STS, v); chk("R9 timing counts from restart", v, 32'h0);
        @(negedge clk);
        rd(A_STS, v); chk("R9 finish after restart", v, 32'h1);
        rd(A_QUO, v); chk("R9 quotient latest", v, 32'hFFFF_FF72);
        rd(A_REM, v); chk("R9 remainder latest", v, 32'd6);

        // R11 dividend rewrite during busy
        wr(A_DVD, 32'hFFFF_FFCE);
        wr(A_DVS, 32'd6);
        repeat (5) @(negedge clk);
        wr(A_DVD, 32'd999);
        wait_done();
        rd(A_QUO, v); chk("R11 quotient uses captured dividend", v, 32'hFFFF_FFF8);
        rd(A_REM, v); chk("R11 remainder uses captured dividend", v, 32'hFFFF_FFFE);
        rd(A_DVD, v); chk("R11 dividend readback", v, 32'd999);

        // R10 writes to result and status offsets ignored
        wr(A_STS, 32'hFFFF_FFFE);
        rd(A_STS, v); chk("R10 status write ignored", v, 32'h1);
        wr(A_QUO, 32'h1234_5678);
        rd(A_QUO, v); chk("R10 quotient write ignored", v, 32'hFFFF_FFF8);
        wr(A_REM, 32'h1234_5678);
        rd(A_REM, v); chk("R10 remainder write ignored", v, 32'hFFFF_FFFE);
        repeat (5) @(negedge clk);
        rd(A_QUO, v); chk("R10 quotient holds", v, 32'hFFFF_FFF8);

        // random mix
        for (int n = 0; n < 150; n++) begin
            int sel;
            a = $urandom();
            sel = $urandom_range(0, 7);
            case (sel)
                0: b = 16'h0;
                1: b = 16'h8000;
                2: b = 16'hFFFF;
                3: b = 16'h7FFF;
                default: b = 16'($urandom());
            endcase
            if ($urandom_range(0, 9) == 0) a = 32'h8000_0000;
            run_op("R3 random", a, b);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule